// File: doc/BRIEF.md
# Split-Mode Signed Multiplier Tile

This tile multiplies two 18-bit operands and delivers the result on a single 36-bit product bus. A mode input chooses how the buses are used. In wide mode the tile computes one 18x18 product. In split mode it computes two independent 9x9 products: one from the low operand halves and one from the high halves. Two run-time flags choose, for each operand separately, whether its bits are read as two's complement or as unsigned. In split mode the same two flags apply to both lanes.

The operand stage and the product stage can each be registered or left combinational, chosen by parameters. The default registers both stages. A clock enable freezes every register. A synchronous reset clears them all and takes priority over the clock enable. The tile does no accumulation and has no pre-adder and no cascade path.

Top module: `splitmul_tile`

## Requirements
- R1: In wide mode (`splitSel`=0) with both sign flags 0, `prod` is the unsigned 36-bit product of `opA` and `opB`.
- R2: In wide mode with both sign flags 1, both operands are two's complement and `prod` is their 36-bit two's-complement product. For example, -131072 x -131072 gives 2^34 and -1 x -1 gives 1.
- R3: When exactly one sign flag is 1, that operand is sign-extended and the other is zero-extended. The product is a two's-complement number. This applies in either mode.
- R4: In split mode (`splitSel`=1), `prod[17:0]` is the product of `opA[8:0]` and `opB[8:0]`, and `prod[35:18]` is the product of `opA[17:9]` and `opB[17:9]`. No bit passes between the lanes.
- R5: In split mode, `sgnA` and `sgnB` set the interpretation of the A and B halves in both lanes. Each lane's 18-bit result is two's complement whenever either of its operands is signed. This includes -256 x -256 = 65536.
- R6: With `REG_IN`=1 and `REG_OUT`=1 (the default), the result for inputs sampled at one enabled edge appears after the second enabled edge. With both parameters 0, `prod` follows the inputs combinationally.
- R7: While `ce` is 0 and `srst` is 0, no register changes, so `prod` holds its value whatever the inputs do.
- R8: `srst`=1 at a clock edge clears every operand and product register to zero, whatever the value of `ce`. `prod` reads zero after that edge.
- R9: A zero operand gives a zero result in the lane it feeds. A zero full operand gives a zero `prod` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| ce | input | 1 | Clock enable for all registers |
| srst | input | 1 | Synchronous reset, active high |
| opA | input | 18 | Operand A (low half and high half in split mode) |
| opB | input | 18 | Operand B (low half and high half in split mode) |
| sgnA | input | 1 | 1 = operand A is two's complement |
| sgnB | input | 1 | 1 = operand B is two's complement |
| splitSel | input | 1 | 0 = one 18x18 product, 1 = two 9x9 products |
| prod | output | 36 | Product bus |

## Verification
The bench drives the most-negative 18-bit and 9-bit values, all-ones patterns and lane-boundary patterns under all four sign settings in both modes. A design that extends the wrong operand, or treats the mixed case as unsigned, gives results that are wrong by a multiple of 2^18 or 2^9. A lane that leaks into its neighbour corrupts `prod[35:18]` whenever the low product is negative. Further phases toggle `ce` and pulse `srst` while the enable is low, and a combinational build is checked alongside the registered one. These catch an off-by-one latency, a register that ignores the enable, and a reset that waits for the enable.

// File: rtl/splitmul_pkg.sv
package splitmul_pkg;

  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } mulMode_e;

  typedef struct packed {
    logic clrIn;
    logic ldIn;
    logic clrOut;
    logic ldOut;
  } mulStrobe_t;

endpackage

// File: rtl/splitmul_lane.sv
module splitmul_lane #(
  parameter int N = 9
) (
  input  logic [N-1:0]   xIn,
  input  logic [N-1:0]   yIn,
  input  logic           xSigned,
  input  logic           ySigned,
  output logic [2*N-1:0] pOut
);
  localparam int EW = N + 1;
  localparam int FW = 2 * N + 2;

  logic signed [EW-1:0] xExt;
  logic signed [EW-1:0] yExt;
  logic signed [FW-1:0] fullP;

  // one extra bit makes both unsigned and signed operands fit a signed multiply
  always_comb begin
    xExt  = {xSigned & xIn[N-1], xIn};
    yExt  = {ySigned & yIn[N-1], yIn};
    fullP = FW'(xExt) * FW'(yExt);
    pOut  = fullP[2*N-1:0];
  end

  logic unusedTop;
  assign unusedTop = ^fullP[FW-1:2*N];
endmodule

// File: rtl/splitmul_ctl.sv
module splitmul_ctl
  import splitmul_pkg::*;
(
  input  logic       ce,
  input  logic       srst,
  output mulStrobe_t strobe
);
  // reset wins over enable for both register stages
  always_comb begin
    strobe.clrIn  = srst;
    strobe.ldIn   = ce & ~srst;
    strobe.clrOut = srst;
    strobe.ldOut  = ce & ~srst;
  end
endmodule

// File: rtl/splitmul_dp.sv
module splitmul_dp
  import splitmul_pkg::*;
#(
  parameter int OP_W    = 18,
  parameter bit REG_IN  = 1'b1,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  mulStrobe_t       strobe,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  input  logic             sgnA,
  input  logic             sgnB,
  input  logic             splitSel,
  output logic [2*OP_W-1:0] prod
);
  localparam int HW    = OP_W / 2;
  localparam int PW    = 2 * OP_W;
  localparam int LANES = 2;

  logic [OP_W-1:0] aReg, bReg, aUse, bUse;
  logic            saReg, sbReg, saUse, sbUse;
  mulMode_e        modeReg, modeUse;

  always_ff @(posedge clk) begin
    if (strobe.clrIn) begin
      aReg    <= '0;
      bReg    <= '0;
      saReg   <= 1'b0;
      sbReg   <= 1'b0;
      modeReg <= MODE_WIDE;
    end else if (strobe.ldIn) begin
      aReg    <= opA;
      bReg    <= opB;
      saReg   <= sgnA;
      sbReg   <= sgnB;
      modeReg <= mulMode_e'(splitSel);
    end
  end

  always_comb begin
    aUse    = REG_IN ? aReg    : opA;
    bUse    = REG_IN ? bReg    : opB;
    saUse   = REG_IN ? saReg   : sgnA;
    sbUse   = REG_IN ? sbReg   : sgnB;
    modeUse = REG_IN ? modeReg : mulMode_e'(splitSel);
  end

  logic [PW-1:0] wideP;
  logic [PW-1:0] halfP;

  splitmul_lane #(.N(OP_W)) u_wideLane (
    .xIn(aUse), .yIn(bUse), .xSigned(saUse), .ySigned(sbUse), .pOut(wideP)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_half
    splitmul_lane #(.N(HW)) u_halfLane (
      .xIn    (aUse[g*HW +: HW]),
      .yIn    (bUse[g*HW +: HW]),
      .xSigned(saUse),
      .ySigned(sbUse),
      .pOut   (halfP[g*2*HW +: 2*HW])
    );
  end

  logic [PW-1:0] prodNext, prodReg;
  assign prodNext = (modeUse == MODE_SPLIT) ? halfP : wideP;

  always_ff @(posedge clk) begin
    if (strobe.clrOut)     prodReg <= '0;
    else if (strobe.ldOut) prodReg <= prodNext;
  end

  assign prod = REG_OUT ? prodReg : prodNext;
endmodule

// File: rtl/splitmul_tile.sv
module splitmul_tile
  import splitmul_pkg::*;
#(
  parameter int OP_W    = 18,
  parameter bit REG_IN  = 1'b1,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              srst,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic              sgnA,
  input  logic              sgnB,
  input  logic              splitSel,
  output logic [2*OP_W-1:0] prod
);
  mulStrobe_t strobe;

  splitmul_ctl u_ctl (.ce(ce), .srst(srst), .strobe(strobe));

  splitmul_dp #(.OP_W(OP_W), .REG_IN(REG_IN), .REG_OUT(REG_OUT)) u_dp (
    .clk(clk), .strobe(strobe), .opA(opA), .opB(opB), .sgnA(sgnA),
    .sgnB(sgnB), .splitSel(splitSel), .prod(prod)
  );
endmodule

// File: rtl/splitmul_tile_chk.sv
module splitmul_tile_chk #(
  parameter int OP_W    = 18,
  parameter bit REG_IN  = 1'b1,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              ce,
  input logic              srst,
  input logic [OP_W-1:0]   opA,
  input logic [OP_W-1:0]   opB,
  input logic              splitSel,
  input logic [2*OP_W-1:0] prod
);
  localparam int HW  = OP_W / 2;
  localparam int LAT = int'(REG_IN) + int'(REG_OUT);

  // zero-operand flags travel alongside the data: [0] whole, [1] low lane, [2] high lane
  logic [2:0] zc [0:LAT];

  assign zc[0][0] = (opA == '0) || (opB == '0);
  assign zc[0][1] = splitSel && ((opA[HW-1:0] == '0) || (opB[HW-1:0] == '0));
  assign zc[0][2] = splitSel && ((opA[OP_W-1:HW] == '0) || (opB[OP_W-1:HW] == '0));

  for (genvar k = 1; k <= LAT; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (srst)    zc[k] <= 3'b111;
      else if (ce) zc[k] <= zc[k-1];
    end
  end

  p_zero_full_r9: assert property (@(posedge clk) disable iff (srst)
    zc[LAT][0] |-> (prod == '0));
  p_zero_low_lane_r4: assert property (@(posedge clk) disable iff (srst)
    zc[LAT][1] |-> (prod[2*HW-1:0] == '0));
  p_zero_high_lane_r4: assert property (@(posedge clk) disable iff (srst)
    zc[LAT][2] |-> (prod[2*OP_W-1:2*HW] == '0));

  if (LAT > 0) begin : g_seq
    p_clear_r8: assert property (@(posedge clk)
      srst |=> (prod == '0));
    p_hold_r7: assert property (@(posedge clk) disable iff (srst)
      !ce |=> $stable(prod));
  end
endmodule

bind splitmul_tile splitmul_tile_chk #(.OP_W(OP_W), .REG_IN(REG_IN), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .ce(ce), .srst(srst), .opA(opA), .opB(opB),
  .splitSel(splitSel), .prod(prod)
);

// File: tb/splitmul_tile_bench.sv
module splitmul_tile_bench;
  localparam int W  = 18;
  localparam int H  = 9;
  localparam int PW = 36;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          ce = 1'b1, srst = 1'b1;
  logic [W-1:0]  opA = '0, opB = '0;
  logic          sgnA = 1'b0, sgnB = 1'b0, splitSel = 1'b0;
  logic [PW-1:0] prod, prodC;
  string         tag = "R8";

  int checks = 0;
  int errors = 0;

  splitmul_tile u_splitmul_tile (
    .clk(clk), .ce(ce), .srst(srst), .opA(opA), .opB(opB), .sgnA(sgnA),
    .sgnB(sgnB), .splitSel(splitSel), .prod(prod)
  );

  splitmul_tile #(.REG_IN(1'b0), .REG_OUT(1'b0)) u_splitmul_tile_comb (
    .clk(clk), .ce(ce), .srst(srst), .opA(opA), .opB(opB), .sgnA(sgnA),
    .sgnB(sgnB), .splitSel(splitSel), .prod(prodC)
  );

  function automatic longint laneRef(longint x, longint y, int n, bit sx, bit sy);
    longint ex, ey, p, one;
    one = 64'sd1;
    ex = (sx && ((x >> (n-1)) & 1) == 1) ? x - (one << n) : x;
    ey = (sy && ((y >> (n-1)) & 1) == 1) ? y - (one << n) : y;
    p  = ex * ey;
    return p & ((one << (2*n)) - 1);
  endfunction

  function automatic logic [PW-1:0] refProd(logic [W-1:0] a, logic [W-1:0] b,
                                            bit sa, bit sb, bit split);
    longint lo, hi, wd;
    if (split) begin
      lo = laneRef(longint'(a[H-1:0]), longint'(b[H-1:0]), H, sa, sb);
      hi = laneRef(longint'(a[W-1:H]), longint'(b[W-1:H]), H, sa, sb);
      return {hi[2*H-1:0], lo[2*H-1:0]};
    end
    wd = laneRef(longint'(a), longint'(b), W, sa, sb);
    return wd[PW-1:0];
  endfunction

  // behavioural pipeline: one operand stage, one product stage
  logic [PW-1:0] expOut = '0;
  logic [W-1:0]  mA = '0, mB = '0;
  bit            mSa, mSb, mSp;
  string         mTag = "R8", outTag = "R8";

  always @(posedge clk) begin
    if (srst) begin
      expOut = '0; outTag = "R8";
      mA = '0; mB = '0; mSa = 0; mSb = 0; mSp = 0; mTag = "R8";
    end else if (ce) begin
      expOut = refProd(mA, mB, mSa, mSb, mSp);
      outTag = mTag;
      mA = opA; mB = opB; mSa = sgnA; mSb = sgnB; mSp = splitSel; mTag = tag;
    end
  end

  bit started = 0;
  always @(negedge clk) begin
    logic [PW-1:0] expC;
    if (started) begin
      checks++;
      if (prod !== expOut) begin
        errors++;
        $display("FAIL %s (R6 registered) prod=%h expected=%h", outTag, prod, expOut);
      end
      expC = refProd(opA, opB, sgnA, sgnB, splitSel);
      checks++;
      if (prodC !== expC) begin
        errors++;
        $display("FAIL %s (R6 combinational) prod=%h expected=%h", tag, prodC, expC);
      end
    end
  end

  task automatic put(logic [W-1:0] a, logic [W-1:0] b, bit sa, bit sb, bit sp,
                     bit e, bit r, string t);
    @(posedge clk); #1;
    opA = a; opB = b; sgnA = sa; sgnB = sb; splitSel = sp; ce = e; srst = r; tag = t;
  endtask

  function automatic string pickTag(bit sp, bit sa, bit sb, logic [W-1:0] a, logic [W-1:0] b);
    if (a == '0 || b == '0) return "R9";
    if (sp) return (sa || sb) ? "R5" : "R4";
    if (sa && sb) return "R2";
    if (sa || sb) return "R3";
    return "R1";
  endfunction

  logic [W-1:0] edgeV [8];

  initial begin
    edgeV[0] = 18'h20000; edgeV[1] = 18'h3FFFF; edgeV[2] = 18'h1FFFF; edgeV[3] = 18'h00001;
    edgeV[4] = 18'h00000; edgeV[5] = 18'h20100; edgeV[6] = 18'h1FEFF; edgeV[7] = 18'h001FF;
    repeat (3) @(posedge clk);
    #1 started = 1;
    // R8: reset state, both outputs checked at the next negedge by the monitor
    put('0, '0, 0, 0, 0, 1, 1, "R8");
    put('0, '0, 0, 0, 0, 1, 0, "R6");
    // R6: single-cycle pulse, watched through the pipeline
    put(18'd3, 18'd5, 0, 0, 0, 1, 0, "R6");
    put('0, 18'd7, 0, 0, 0, 1, 0, "R6");
    put('0, '0, 0, 0, 0, 1, 0, "R6");
    // R1..R5, R9: all sign settings, both modes, edge values
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            put(edgeV[i], edgeV[j], s[1], s[0], m[0], 1, 0,
                pickTag(m[0], s[1], s[0], edgeV[i], edgeV[j]));
        for (int k = 0; k < 40; k++) begin
          logic [W-1:0] ra, rb;
          ra = W'($urandom); rb = W'($urandom);
          put(ra, rb, s[1], s[0], m[0], 1, 0, pickTag(m[0], s[1], s[0], ra, rb));
        end
      end
    // R7: enable low while inputs keep changing
    put(18'h12345, 18'h2ABCD, 1, 0, 0, 1, 0, "R7");
    for (int k = 0; k < 6; k++)
      put(W'($urandom), W'($urandom), k[0], k[1], k[0], 0, 0, "R7");
    put(18'h00FF0, 18'h3000F, 1, 1, 1, 1, 0, "R7");
    put(18'h0F0F0, 18'h1234, 0, 1, 0, 1, 0, "R7");
    // R8: reset while enable is low still clears
    put(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0, 1, "R8");
    put(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0, 0, "R8");
    put(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 1, 0, "R8");
    repeat (4) put('0, '0, 0, 0, 0, 1, 0, "R9");
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule